// File: doc/BRIEF.md
# SPI Host Controller with Register Interface

This block is a SPI bus host that software drives through a small register window on a 32-bit read/write strobe bus. Words written to a transmit queue are shifted out on the serial data output while the incoming line is sampled. Each word sent yields exactly one received word, which lands in a receive queue for software to read. Clock polarity, clock phase, bit order and an internal loopback path come from a control register. A transmit-inhibit bit lets software fill the queue before any serial activity starts.

Target select lines are active low and come from a select register. In manual mode the pins follow the register at all times. In automatic mode they follow it only while a word is shifting. Seven interrupt status bits are cleared by writing ones. They are masked by an enable register and a global enable, and drive one level interrupt. A keyed write to a reset register returns the whole core to its power-up state. Word width, queue depth, number of selects and the serial clock divider are elaboration parameters.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status (0x64) reads 0x5 (bit0 RX empty, bit2 TX empty), control (0x60) reads 0x100 (bit8 inhibit set), select (0x70) reads all ones, interrupt status (0x20) reads 0, `irq` is low and `spi_sck` is low.
- R2: While control bit8 (inhibit) is set, writes to 0x68 fill the TX queue and no transfer starts (`spi_sck` does not toggle, RX stays empty). Status bit3 (TX full) rises on the write that brings the count to FIFO_DEPTH.
- R3: With control bit1 (enable) and bit2 (host) set and inhibit clear, queued words are sent one after another. Each word pushes exactly one word into the RX queue. Status bit1 (RX full) rises at FIFO_DEPTH received words.
- R4: With control bit0 (loopback) set, the received word equals the transmitted word whatever `spi_miso` carries. Reads of 0x6C pop words in arrival order.
- R5: While no word is shifting, `spi_sck` rests at the level of control bit3 (CPOL).
- R6: Each word spans DATA_W clock periods. Bits are presented on `spi_mosi` so that they are stable at the sampling edge: the leading edge when control bit4 (CPHA) is 0, the trailing edge when it is 1. The MSB goes first, or the LSB first when control bit9 is set.
- R7: With loopback clear, the received word is assembled from `spi_miso` sampled on the sampling edge, in the same bit order.
- R8: With control bit7 (manual select) set, `spi_sel_n` equals the select register. With it clear, `spi_sel_n` is all ones when idle and equals the select register while a word shifts.
- R9: Interrupt status bit2 (TX empty) sets on the cycle after the last bit of a word ends with the TX queue empty. Writing a 1 to a status bit clears it. If a set and a clear fall on the same edge, the set wins.
- R10: `irq` is high exactly when bit31 of 0x1C is set and some status bit is set with its enable bit (0x28) set.
- R11: Status bit4 sets when the RX queue becomes full, bit6 sets when a TX pop leaves FIFO_DEPTH/2 words, and bit5 sets when a word completes with the RX queue full. That word is dropped.
- R12: Writing control bit5 (or bit6) empties the TX (or RX) queue at once. Neither bit is stored: control reads it back as 0.
- R13: Writing 0x0A to 0x40 restores every register, both queues and the outputs to the reset state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_sel_n | output | NUM_SEL | Active-low target selects |
| irq | output | 1 | Level interrupt |

## Verification
Two things can land on one clock edge: a software write-one-to-clear of the TX-empty status bit, and the hardware setting of that same bit when a word finishes. The bench counts the exact completion edge from the divider and word width. It then sweeps the clear write across a seven-cycle window around that edge, one trial per offset. A clear at or before the set edge must leave the bit at 1, and a clear after it must leave 0. A second collision, a finished word arriving at a full RX queue, is forced by queueing one word more than the depth. It is judged by the overrun bit and by the read-back order of the retained words.

// File: rtl/spih_pkg.sv
// Shared register offsets, bit positions and the serial shape record
// for the SPI host controller. Assumes byte addressing on an 8-bit offset.
package spih_pkg;

    localparam logic [7:0] A_GIE  = 8'h1C;
    localparam logic [7:0] A_ISR  = 8'h20;
    localparam logic [7:0] A_IER  = 8'h28;
    localparam logic [7:0] A_SRST = 8'h40;
    localparam logic [7:0] A_CTRL = 8'h60;
    localparam logic [7:0] A_STAT = 8'h64;
    localparam logic [7:0] A_TXD  = 8'h68;
    localparam logic [7:0] A_RXD  = 8'h6C;
    localparam logic [7:0] A_SEL  = 8'h70;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    localparam int C_LOOP  = 0;
    localparam int C_EN    = 1;
    localparam int C_HOST  = 2;
    localparam int C_CPOL  = 3;
    localparam int C_CPHA  = 4;
    localparam int C_TXCLR = 5;
    localparam int C_RXCLR = 6;
    localparam int C_MAN   = 7;
    localparam int C_INH   = 8;
    localparam int C_LSB   = 9;

    localparam logic [9:0] CTRL_KEEP = 10'h39F;
    localparam logic [9:0] CTRL_INIT = 10'h100;

    localparam int I_TXE = 2;
    localparam int I_RXF = 4;
    localparam int I_RXO = 5;
    localparam int I_TXH = 6;
    localparam int NIRQ  = 7;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb;
        logic loop;
    } shape_t;

endpackage

// File: rtl/spih_fifo.sv
// Synchronous FIFO built from a flop array with read/write pointers and
// an occupancy counter. Assumes the caller never relies on a push while
// full (it is dropped) nor a pop while empty (it is ignored). The clr
// input empties the queue on the next edge and takes priority.
module spih_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy on push, pop or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> full); // R2

endmodule

// File: rtl/spih_shift.sv
// Serial shift engine. On start it loads one word and produces 2*W half
// periods of the serial clock, each CLK_DIV core cycles long. It samples
// on the leading or trailing edge as CPHA selects and drives out the
// opposite way. It pulses done for one cycle after the final edge, with
// rx_word holding the received word. Assumes W >= 2 and a stable shape
// for the whole word.
module spih_shift
    import spih_pkg::*;
#(
    parameter int W       = 8,
    parameter int CLK_DIV = 2,
    localparam int HW     = $clog2(2 * W),
    localparam int DVW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    input  shape_t       shape,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_word,
    output logic         sck,
    output logic         mosi
);

    logic [DVW-1:0] div_q;
    logic [HW-1:0]  half_q;
    logic [W-1:0]   tx_sh, rx_sh;
    logic           sck_q;
    logic           tick, samp, shft, din;

    assign tick    = busy && (div_q == DVW'(CLK_DIV - 1));
    assign samp    = tick && (shape.cpha ? half_q[0] : !half_q[0]);
    assign shft    = tick && (shape.cpha ? (!half_q[0] && half_q != '0) : half_q[0]);
    assign mosi    = shape.lsb ? tx_sh[0] : tx_sh[W-1];
    assign din     = shape.loop ? mosi : miso;
    assign sck     = sck_q;
    assign rx_word = rx_sh;

    // Sequence one word: load, divide, toggle, sample, shift, finish.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            div_q  <= '0;
            half_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sck_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                sck_q <= shape.cpol;
                if (start) begin
                    busy   <= 1'b1;
                    tx_sh  <= tx_word;
                    div_q  <= '0;
                    half_q <= '0;
                end
            end else if (tick) begin
                div_q <= '0;
                sck_q <= ~sck_q;
                if (samp)
                    rx_sh <= shape.lsb ? {din, rx_sh[W-1:1]} : {rx_sh[W-2:0], din};
                if (shft)
                    tx_sh <= shape.lsb ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
                if (half_q == HW'(2 * W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $past(shape.cpol) == shape.cpol && !$past(clr))
            |-> sck == shape.cpol); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R3

endmodule

// File: rtl/spi_host_ctrl.sv
// SPI host controller top: register decode, two queues, the shift engine,
// select drive and interrupt logic. Reads return data one cycle after the
// read strobe; a read of the RX data offset pops that queue. Assumes
// DATA_W is 8, 16 or 32 and NUM_SEL is at most 32.
module spi_host_ctrl
    import spih_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int NUM_SEL    = 4,
    parameter int SCK_DIV    = 2,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int HALF      = FIFO_DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               spi_sck,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [NUM_SEL-1:0] spi_sel_n,
    output logic               irq
);

    logic [9:0]         ctrl_q;
    logic [NUM_SEL-1:0] sel_q;
    logic [NIRQ-1:0]    isr_q, ier_q, isr_set, w1c;
    logic               gie_q;
    logic [31:0]        rdata_q;

    logic wr_ctrl, wr_isr, soft_rst;
    logic tx_push, tx_pop, tx_clr, tx_empty, tx_full;
    logic rx_push, rx_pop, rx_clr, rx_empty, rx_full;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_dout, rx_dout, sh_rx;
    logic sh_busy, sh_done, start;
    shape_t shape;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign wr_isr   = bus_wr && bus_addr == A_ISR;
    assign soft_rst = bus_wr && bus_addr == A_SRST && bus_wdata == SRST_KEY;

    assign shape.cpol = ctrl_q[C_CPOL];
    assign shape.cpha = ctrl_q[C_CPHA];
    assign shape.lsb  = ctrl_q[C_LSB];
    assign shape.loop = ctrl_q[C_LOOP];

    assign start   = ctrl_q[C_EN] && ctrl_q[C_HOST] && !ctrl_q[C_INH] && !tx_empty && !sh_busy;
    assign tx_push = bus_wr && bus_addr == A_TXD;
    assign tx_pop  = start;
    assign tx_clr  = soft_rst || (wr_ctrl && bus_wdata[C_TXCLR]);
    assign rx_push = sh_done && !rx_full;
    assign rx_pop  = bus_rd && bus_addr == A_RXD && !rx_empty;
    assign rx_clr  = soft_rst || (wr_ctrl && bus_wdata[C_RXCLR]);

    spih_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .din(bus_wdata[DATA_W-1:0]), .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    spih_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
        .din(sh_rx), .pop(rx_pop), .dout(rx_dout),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    spih_shift #(.W(DATA_W), .CLK_DIV(SCK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .start(start),
        .tx_word(tx_dout), .shape(shape), .miso(spi_miso),
        .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
        .sck(spi_sck), .mosi(spi_mosi)
    );

    // Collect the hardware events that raise interrupt status bits.
    always_comb begin
        isr_set          = '0;
        isr_set[I_TXE]   = sh_done && tx_empty;
        isr_set[I_RXF]   = rx_push && !rx_pop && rx_cnt == CW'(FIFO_DEPTH - 1);
        isr_set[I_RXO]   = sh_done && rx_full;
        isr_set[I_TXH]   = tx_pop && !tx_push && tx_cnt == CW'(HALF + 1);
        w1c              = wr_isr ? bus_wdata[NIRQ-1:0] : '0;
    end

    // Hold the software-visible configuration and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTRL_INIT;
            sel_q  <= '1;
            ier_q  <= '0;
            isr_q  <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[9:0] & CTRL_KEEP;
            if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata[NUM_SEL-1:0];
            if (bus_wr && bus_addr == A_IER) ier_q <= bus_wdata[NIRQ-1:0];
            if (bus_wr && bus_addr == A_GIE) gie_q <= bus_wdata[31];
            isr_q <= (isr_q & ~w1c) | isr_set;
        end
    end

    // Register the read data selected by the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  rdata_q <= {22'd0, ctrl_q};
                A_STAT:  rdata_q <= {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
                A_RXD:   rdata_q <= 32'(rx_dout);
                A_SEL:   rdata_q <= 32'(sel_q);
                A_ISR:   rdata_q <= 32'(isr_q);
                A_IER:   rdata_q <= 32'(ier_q);
                A_GIE:   rdata_q <= {gie_q, 31'd0};
                default: rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = gie_q && |(isr_q & ier_q);
    assign spi_sel_n = (ctrl_q[C_MAN] || sh_busy) ? sel_q : '1;

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_busy && ctrl_q[C_INH]) |=> !sh_busy); // R2

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq); // R10

    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_MAN] && !sh_busy) |-> &spi_sel_n); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_done && tx_empty && !soft_rst) |=> isr_q[I_TXE]); // R9

endmodule

// File: tb/test_spi_host_ctrl.sv
// Self-checking bench for spi_host_ctrl: register defaults, queue fill and
// drain, a sweep of all eight serial shapes, select modes, a cycle sweep of
// a clear against a status set, overrun, queue resets and soft reset.
module test_spi_host_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW = 8, DEPTH = 4, NSEL = 4, DIV = 2;
    localparam logic [7:0] GIE = 8'h1C, ISR = 8'h20, IER = 8'h28, SRST = 8'h40,
                           CTRL = 8'h60, STAT = 8'h64, TXD = 8'h68, RXD = 8'h6C, SEL = 8'h70;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic spi_sck, spi_mosi, spi_miso, irq;
    logic [NSEL-1:0] spi_sel_n;

    spi_host_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .NUM_SEL(NSEL), .SCK_DIV(DIV)) i_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_sel_n(spi_sel_n), .irq(irq)
    );

    assign spi_miso = ~spi_mosi;   // target model: inverted echo
    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    logic mon_on = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0;
    logic [31:0] cap = '0;
    int cap_n = 0, sck_edges = 0;

    // Capture mosi on each sampling edge of the serial clock.
    always @(spi_sck) begin
        sck_edges++;
        if (mon_on && ((spi_sck != b_cpol) ^ b_cpha)) begin
            #1;
            cap = {cap[30:0], spi_mosi};
            cap_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7 - i];
        return r;
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements unfinished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n, e0;
        logic [7:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(STAT, v); check("R1 status", v, 32'h5);
        rd(CTRL, v); check("R1 control", v, 32'h100);
        rd(SEL, v);  check("R1 select", v, 32'hF);
        rd(ISR, v);  check("R1 isr", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 sck", {31'd0, spi_sck}, 32'd0);

        // R2 fill under inhibit, discover depth through the full flag
        wr(CTRL, 32'h107);
        n = 0;
        do begin
            wr(TXD, 32'h10 + n); n++;
            rd(STAT, v);
        end while (!v[3] && n < 10);
        check("R2 depth by full flag", n, DEPTH);
        e0 = sck_edges;
        idle(100);
        check("R2 no sck while inhibited", sck_edges - e0, 0);
        rd(STAT, v); check("R2 rx empty tx busy", v & 32'h5, 32'h1);

        // R3 release drains; one RX word per TX word
        wr(CTRL, 32'h007);
        idle(200);
        rd(STAT, v); check("R3 tx empty rx full", v[3:0], 32'h6);
        for (int i = 0; i < DEPTH; i++) begin
            rd(RXD, v); check("R4 loopback order", v, 32'h10 + i);
        end
        rd(STAT, v); check("R3 drained", v, 32'h5);

        // R5 R6 R4 sweep of every shape
        for (int m = 0; m < 8; m++) begin
            mon_on = 1'b0; b_cpol = m[0]; b_cpha = m[1];
            wr(CTRL, 32'h7 | (m[0] ? 32'h8 : 0) | (m[1] ? 32'h10 : 0) | (m[2] ? 32'h200 : 0));
            idle(3);
            check("R5 idle sck level", {31'd0, spi_sck}, {31'd0, b_cpol});
            for (int j = 0; j < 3; j++) begin
                w = (j == 0) ? 8'h01 : (j == 1) ? 8'h80 : 8'(8'h5A ^ (m * 37));
                cap = '0; cap_n = 0; mon_on = 1'b1;
                wr(TXD, {24'd0, w});
                idle(40);
                mon_on = 1'b0;
                check("R6 bits per word", cap_n, DW);
                check("R6 bit order", cap[7:0], m[2] ? rev8(w) : w);
                rd(RXD, v); check("R4 loopback ignores miso", v, {24'd0, w});
                idle(2);
                check("R5 sck rests after word", {31'd0, spi_sck}, {31'd0, b_cpol});
            end
        end

        // R7 external sampling of an inverting target
        for (int p = 0; p < 2; p++) begin
            wr(CTRL, 32'h6 | (p == 1 ? 32'h10 : 0));
            wr(TXD, 32'hC3);
            idle(40);
            rd(RXD, v); check("R7 miso capture", v, 32'h3C);
        end

        // R8 manual and automatic select
        wr(CTRL, 32'h187);
        wr(SEL, 32'hA);
        check("R8 manual select", spi_sel_n, 4'hA);
        wr(SEL, 32'hE);
        wr(CTRL, 32'h007);
        check("R8 auto idle", spi_sel_n, 4'hF);
        wr(TXD, 32'h55);
        idle(10);
        check("R8 auto active", spi_sel_n, 4'hE);
        idle(40);
        check("R8 auto released", spi_sel_n, 4'hF);
        rd(RXD, v);

        // R9 clear write swept across the set edge (set lands at P0+34)
        for (int k = 31; k <= 37; k++) begin
            wr(ISR, 32'h7F);
            wr(TXD, 32'h33);
            repeat (k - 1) @(negedge clk);
            wr(ISR, 32'h4);
            idle(20);
            rd(ISR, v);
            check($sformatf("R9 set vs clear offset %0d", k), v & 32'h4, (k <= 34) ? 32'h4 : 32'h0);
            rd(RXD, v);
        end

        // R10 interrupt gating
        wr(TXD, 32'h11);
        idle(40);
        rd(RXD, v);
        wr(IER, 32'h4);
        check("R10 global off", {31'd0, irq}, 0);
        wr(GIE, 32'h8000_0000);
        check("R10 enabled", {31'd0, irq}, 1);
        wr(IER, 32'h0);
        check("R10 masked", {31'd0, irq}, 0);
        wr(IER, 32'h4);
        check("R10 reenabled", {31'd0, irq}, 1);
        wr(ISR, 32'h4);
        check("R10 cleared", {31'd0, irq}, 0);

        // R11 rx full, half empty, overrun
        wr(CTRL, 32'h107);
        for (int i = 0; i < DEPTH; i++) wr(TXD, 32'h20 + i);
        wr(ISR, 32'h7F);
        wr(CTRL, 32'h007);
        idle(200);
        rd(ISR, v); check("R11 full and half flags", v, 32'h54);
        wr(TXD, 32'h99);
        idle(50);
        rd(ISR, v); check("R11 overrun", v & 32'h20, 32'h20);
        for (int i = 0; i < DEPTH; i++) begin
            rd(RXD, v); check("R11 retained words", v, 32'h20 + i);
        end
        rd(STAT, v); check("R11 extra word dropped", v & 32'h1, 32'h1);

        // R12 queue reset bits
        wr(CTRL, 32'h107);
        wr(TXD, 32'h1); wr(TXD, 32'h2);
        rd(STAT, v); check("R12 tx holds", v & 32'h4, 32'h0);
        wr(CTRL, 32'h127);
        rd(STAT, v); check("R12 tx emptied", v, 32'h5);
        rd(CTRL, v); check("R12 tx bit reads zero", v, 32'h107);
        wr(CTRL, 32'h007);
        wr(TXD, 32'h44);
        idle(40);
        rd(STAT, v); check("R12 rx holds", v & 32'h1, 32'h0);
        wr(CTRL, 32'h047);
        rd(STAT, v); check("R12 rx emptied", v & 32'h1, 32'h1);
        rd(CTRL, v); check("R12 rx bit reads zero", v, 32'h007);

        // R13 keyed soft reset
        wr(SEL, 32'h3); wr(IER, 32'h7F); wr(GIE, 32'h8000_0000);
        wr(CTRL, 32'h10F);
        wr(TXD, 32'h7);
        wr(SRST, 32'h0A);
        rd(CTRL, v); check("R13 control", v, 32'h100);
        rd(STAT, v); check("R13 status", v, 32'h5);
        rd(SEL, v);  check("R13 select", v, 32'hF);
        rd(IER, v);  check("R13 enables", v, 32'h0);
        rd(GIE, v);  check("R13 global", v, 32'h0);
        check("R13 irq", {31'd0, irq}, 0);
        check("R13 sck", {31'd0, spi_sck}, 0);

        finish_run();
    end
endmodule